// File: doc/BRIEF.md
# Serial Receive FIFO with Trigger and Flow-Control Thresholds

This block is the receive half of a buffered serial port. A shift engine hands over each received byte with a one-cycle push strobe. Software drains the bytes through a small register window, and that window also holds a control word, a status word and a line status word. The control word carries two thresholds that are set independently. One is a four-step trigger level: it decides whether software sees "receive full" or only "data ready". The other is an eight-step limit that drives an `accept` output back to the shift engine for flow control.

The buffer holds 16 bytes. A byte that arrives while the buffer is full and nothing is popped is discarded, and an overrun bit is recorded. Reading the line status register returns its value and then clears it. The two receive flags are held in registers and are re-evaluated only when a byte is actually stored or removed. Rewriting the trigger field alone therefore leaves them as they were.

Register reads are combinational on `reg_rdata` in the cycle where `reg_rd` is high. Their side effects (pop, clear) take effect at the next clock edge.

Top module: `rx_trig_fifo`

## Requirements
- R1: The block holds up to 16 bytes and returns them in arrival order, including across pointer wrap-around. Reading select code 0 (data) with `reg_rd` pops the oldest byte, and that byte appears on `reg_rdata[7:0]` in the same cycle.
- R2: A push while 16 bytes are held and no pop happens in that cycle discards the byte and sets bit 0 of the line status register (select code 3).
- R3: The control register (select code 1) keeps only bits [11:7]; its other bits read as zero. Bits [8:7] pick the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8, 3 gives 14.
- R4: After a stored push or a pop, the status register (select code 2) behaves as follows. Bit 1 (receive full) is set when the new count is at or above the trigger level. Bit 0 (data ready) is set when the new count is non-zero and below the trigger level. The two bits are never set together.
- R5: The two receive flags change only on a stored push or a pop. A control write by itself does not change them.
- R6: `accept` is high while the count is below the limit picked by control bits [11:9]. The codes 0 through 7 map to 15, 1, 4, 6, 8, 10, 12 and 14. Bytes pushed while `accept` is low are still stored when there is room.
- R7: A line status read returns the register and then clears it. A line status write loads bit 0 from `reg_wdata[0]`. A discarded push in the same cycle sets the bit regardless of either.
- R8: After reset, the status register reads 0x0060 (bits 6:5 are fixed at one), and the line status and control registers read zero.
- R9: A data read while empty returns zero and changes nothing. Writes to the data and status selects are ignored.
- R10: A push and a pop in the same cycle leave the count unchanged and never report an overrun, even when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Byte strobe from the shift engine |
| push_data | input | 8 | Received byte |
| accept | output | 1 | Flow-control permission to the shift engine |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 data, 1 control, 2 status, 3 line status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for the selected register |

## Verification
The bench builds the block with its default depth of 16 and 8-bit bytes. That depth makes every trigger level, including 14, and every flow limit, including 15, reachable within a few dozen pushes. The bench fills the buffer to the brim repeatedly, so it can press a discard against a simultaneous pop and against a line status read or write in the same cycle. Pointer wrap is reached after sixteen pops, and randomized traffic crosses it many times.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_LINE = 2'd3
    } rxf_sel_e;

    localparam int TRIG_LSB = 7;
    localparam int FLOW_LSB = 9;
    localparam int CTRL_W   = 5;

    // trigger level chosen by the 2-bit field
    function automatic int trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    // flow-control limit chosen by the 3-bit field
    function automatic int flow_limit(input logic [2:0] code);
        if (code == 3'd0)      return 15;
        else if (code == 3'd1) return 1;
        else                   return 2 * int'(code);
    endfunction

endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(g))) cell_q[g] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/rxf_thresh.sv
module rxf_thresh
    import rxf_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [1:0]    trig_code,
    input  logic [2:0]    flow_code,
    input  logic [CW-1:0] cnt_next,
    input  logic [CW-1:0] cnt_now,
    output logic          full_hit,
    output logic          has_data,
    output logic          accept
);
    always_comb begin
        full_hit = int'(cnt_next) >= trig_level(trig_code);
        has_data = cnt_next != '0;
        accept   = int'(cnt_now) < flow_limit(flow_code);
    end
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
    import rxf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int RW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          accept,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [RW-1:0] STAT_FIXED = RW'(16'h0060);

    typedef struct packed {
        logic [AW-1:0]     wptr;
        logic [AW-1:0]     rptr;
        logic [CW-1:0]     count;
        logic [CTRL_W-1:0] ctrl;
        logic              rdf;
        logic              dr;
        logic              ovr;
    } rxf_state_t;

    rxf_state_t st_d, st_q;

    logic          pop_w, push_ok_w, drop_w, full_w;
    logic [CW-1:0] cnt_next;
    logic          hit_w, nz_w;
    logic [DW-1:0] head_w;
    logic          line_rd_w, line_wr_w;
    logic [CW-1:0] fill_q;

    assign full_w    = st_q.count == CW'(DEPTH);
    assign pop_w     = reg_rd && (reg_sel == SEL_DATA) && (st_q.count != '0);
    assign push_ok_w = push_valid && (!full_w || pop_w);
    assign drop_w    = push_valid && full_w && !pop_w;
    assign line_rd_w = reg_rd && (reg_sel == SEL_LINE);
    assign line_wr_w = reg_wr && (reg_sel == SEL_LINE);
    assign fill_q    = st_q.count;

    always_comb begin
        case ({push_ok_w, pop_w})
            2'b10:   cnt_next = st_q.count + CW'(1);
            2'b01:   cnt_next = st_q.count - CW'(1);
            default: cnt_next = st_q.count;
        endcase
    end

    rxf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (push_ok_w),
        .waddr (st_q.wptr),
        .wdata (push_data),
        .raddr (st_q.rptr),
        .rdata (head_w)
    );

    rxf_thresh #(.CW(CW)) u_thr (
        .trig_code (st_q.ctrl[TRIG_LSB-TRIG_LSB +: 2]),
        .flow_code (st_q.ctrl[FLOW_LSB-TRIG_LSB +: 3]),
        .cnt_next  (cnt_next),
        .cnt_now   (st_q.count),
        .full_hit  (hit_w),
        .has_data  (nz_w),
        .accept    (accept)
    );

    always_comb begin
        st_d       = st_q;
        st_d.count = cnt_next;
        if (push_ok_w) st_d.wptr = st_q.wptr + AW'(1);
        if (pop_w)     st_d.rptr = st_q.rptr + AW'(1);

        // flags follow the occupancy only when it actually moves
        if (push_ok_w || pop_w) begin
            st_d.rdf = hit_w;
            st_d.dr  = !hit_w && nz_w;
        end

        if (reg_wr && (reg_sel == SEL_CTRL))
            st_d.ctrl = reg_wdata[TRIG_LSB +: CTRL_W];

        if (line_wr_w)      st_d.ovr = reg_wdata[0];
        else if (line_rd_w) st_d.ovr = 1'b0;
        if (drop_w)         st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_DATA: reg_rdata = (st_q.count != '0) ? RW'(head_w) : '0;
            SEL_CTRL: reg_rdata = RW'({st_q.ctrl, {TRIG_LSB{1'b0}}});
            SEL_STAT: reg_rdata = STAT_FIXED | RW'({st_q.rdf, st_q.dr});
            default:  reg_rdata = RW'(st_q.ovr);
        endcase
    end
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_valid,
    input logic          push_ok,
    input logic          pop,
    input logic [CW-1:0] fill,
    input logic          rdf,
    input logic          dr,
    input logic          ovr,
    input logic          accept,
    input logic          line_rd,
    input logic          line_wr
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) <= DEPTH); // R1
    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && (int'(fill) == DEPTH) && !pop |=> ovr); // R2
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdf && dr)); // R4
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !push_ok && !pop |=> $stable(rdf) && $stable(dr)); // R5
    AST_ACCEPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill) >= DEPTH - 1 |-> !accept); // R6
    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        line_rd && !line_wr && !(push_valid && (int'(fill) == DEPTH) && !pop) |=> !ovr); // R7
    AST_BOTH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop |=> $stable(fill)); // R10
    AST_BOTH_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop && !ovr && !line_wr |=> !ovr); // R10
endmodule

bind rx_trig_fifo rxf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ok    (push_ok_w),
    .pop        (pop_w),
    .fill       (fill_q),
    .rdf        (st_q.rdf),
    .dr         (st_q.dr),
    .ovr        (st_q.ovr),
    .accept     (accept),
    .line_rd    (line_rd_w),
    .line_wr    (line_wr_w)
);

// File: tb/sim_rx_trig_fifo.sv
`timescale 1ns/1ps
module sim_rx_trig_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic        accept;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int total = 0;
    int bad   = 0;

    // behavioural reference
    byte unsigned q[$];
    int ctrl_m = 0, lsr_m = 0, rdf_m = 0, dr_m = 0;

    always #2 clk = ~clk;

    rx_trig_fifo u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .accept(accept), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int m_trig(input int c);
        case ((c >> 7) & 3)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int m_lim(input int c);
        int idx = (c >> 9) & 7;
        if (idx == 0) return 15;
        if (idx == 1) return 1;
        return 2 * idx;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic pv, input logic [7:0] pd, input logic rd,
                       input logic wr, input logic [1:0] sel, input logic [15:0] wd,
                       input string tag);
        int exp_rd, n, t;
        bit pop, full, pok, drop;
        @(negedge clk);
        push_valid = pv; push_data = pd; reg_rd = rd; reg_wr = wr;
        reg_sel = sel; reg_wdata = wd;
        #1;
        n = q.size();
        case (sel)
            2'd0: exp_rd = (n > 0) ? int'(q[0]) : 0;
            2'd1: exp_rd = ctrl_m;
            2'd2: exp_rd = 'h60 | (rdf_m << 1) | dr_m;
            default: exp_rd = lsr_m;
        endcase
        chk(reg_rdata == 16'(exp_rd), {tag, " rdata"}, int'(reg_rdata), exp_rd);
        chk(accept == (n < m_lim(ctrl_m)), {tag, " accept R6"}, int'(accept),
            int'(n < m_lim(ctrl_m)));
        pop  = rd && sel == 2'd0 && n > 0;
        full = n == 16;
        pok  = pv && (!full || pop);
        drop = pv && full && !pop;
        if (pop) void'(q.pop_front());
        if (pok) q.push_back(pd);
        if (pok || pop) begin
            t = m_trig(ctrl_m);
            rdf_m = int'(q.size() >= t);
            dr_m  = int'(q.size() < t && q.size() > 0);
        end
        if (wr && sel == 2'd1) ctrl_m = int'(wd) & 'h0F80;
        if (wr && sel == 2'd3) lsr_m = int'(wd[0]);
        else if (rd && sel == 2'd3) lsr_m = 0;
        if (drop) lsr_m = 1;
    endtask

    task automatic idle(input string tag);             cyc(0, 0, 0, 0, 2'd2, 0, tag); endtask
    task automatic psh(input logic [7:0] b, input string tag); cyc(1, b, 0, 0, 2'd2, 0, tag); endtask
    task automatic rdr(input logic [1:0] s, input string tag); cyc(0, 0, 1, 0, s, 0, tag); endtask
    task automatic wrr(input logic [1:0] s, input logic [15:0] v, input string tag);
        cyc(0, 0, 0, 1, s, v, tag);
    endtask
    task automatic drain(input string tag);
        while (q.size() > 0) rdr(2'd0, tag);
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired R1 actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8 reset values
        rdr(2'd2, "R8 status");
        rdr(2'd3, "R8 line");
        rdr(2'd1, "R8 ctrl");
        // R9 empty read and ignored writes
        rdr(2'd0, "R9 empty read");
        wrr(2'd0, 16'hFFFF, "R9 data write");
        wrr(2'd2, 16'hFFFF, "R9 status write");
        rdr(2'd2, "R9 status unchanged");
        // R3 control masking
        wrr(2'd1, 16'hFFFF, "R3 ctrl mask");
        rdr(2'd1, "R3 ctrl readback");
        wrr(2'd1, 16'h0000, "R3 ctrl clear");
        // R4 trigger 1
        psh(8'hA1, "R4 push trig1");
        rdr(2'd2, "R4 rdf at trig1");
        rdr(2'd0, "R1 pop");
        rdr(2'd2, "R4 flags after empty");
        // R3/R4 trigger 4
        wrr(2'd1, 16'h0080, "R3 trig4");
        for (int i = 0; i < 3; i++) psh(8'(8'h10 + i), "R4 fill");
        rdr(2'd2, "R4 dr below trig");
        // R5 ctrl change alone keeps flags
        wrr(2'd1, 16'h0000, "R5 ctrl to trig1");
        rdr(2'd2, "R5 flags held");
        wrr(2'd1, 16'h0080, "R5 back to trig4");
        psh(8'h13, "R4 fourth");
        rdr(2'd2, "R4 rdf at trig4");
        rdr(2'd0, "R4 pop to 3");
        rdr(2'd2, "R4 dr again");
        drain("R1 drain");
        // R3 triggers 8 and 14
        wrr(2'd1, 16'h0100, "R3 trig8");
        for (int i = 0; i < 8; i++) begin psh(8'(8'h20 + i), "R3 fill8"); rdr(2'd2, "R3 status trig8"); end
        drain("R1 drain8");
        wrr(2'd1, 16'h0180, "R3 trig14");
        for (int i = 0; i < 14; i++) begin psh(8'(8'h30 + i), "R3 fill14"); rdr(2'd2, "R3 status trig14"); end
        // R6 limit sweep at several counts
        for (int k = 0; k < 8; k++) begin wrr(2'd1, 16'(k << 9), "R6 limit"); idle("R6 at 14"); end
        drain("R1 drain14");
        for (int k = 0; k < 8; k++) begin
            wrr(2'd1, 16'(k << 9), "R6 limit");
            for (int i = 0; i < 16; i++) psh(8'(i + 16 * k), "R6 fill past limit");
            idle("R6 full");
            drain("R1 order");
        end
        // R2 overrun and R7 read clear
        wrr(2'd1, 16'h0000, "R2 ctrl");
        for (int i = 0; i < 16; i++) psh(8'(8'h50 + i), "R2 fill");
        psh(8'hEE, "R2 drop");
        rdr(2'd3, "R7 line set");
        rdr(2'd3, "R7 line cleared");
        // R10 simultaneous push and pop at full
        cyc(1, 8'h77, 1, 0, 2'd0, 0, "R10 both at full");
        idle("R10 hold");
        rdr(2'd3, "R10 no overrun");
        // R7 drop beats read clear and write
        cyc(1, 8'h88, 1, 0, 2'd3, 0, "R7 drop with read");
        rdr(2'd3, "R7 drop wins read");
        cyc(1, 8'h89, 0, 1, 2'd3, 0, "R7 drop with write0");
        rdr(2'd3, "R7 drop wins write");
        wrr(2'd3, 16'h0001, "R7 write one");
        rdr(2'd3, "R7 written");
        rdr(2'd3, "R7 cleared");
        drain("R1 drain after overrun");
        // randomized traffic, wraps pointers many times
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] s = 2'($urandom_range(0, 3));
            logic w = ($urandom_range(0, 15) == 0);
            cyc(1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 2) == 0),
                w, s, 16'($urandom), "R1 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule